// File: doc/BRIEF.md
# Boot ROM Overlay Decoder for Bank Zero

This block decides, for every bus cycle, whether an access to the top 16 KiB of bank zero (byte addresses 0x00C000 to 0x00FFFF) is served by the boot ROM or by the RAM underneath it. Reset and interrupt vectors are 16-bit pointers that are always fetched from bank zero, so while reset is held the ROM is forced into that window and the processor can always start from known code. Once running, boot software can copy code into the RAM below the overlay, since writes to the window always land in RAM. It can then turn the ROM off by writing a three-bit control register.

Two further controls shape the window. A write-protect bit makes the RAM in the window behave as read-only: writes to it are dropped silently, with no bus error. A fetch-split mode uses the processor's cycle-type status pins to send only program fetches and vector pulls to ROM, while ordinary data reads and all writes reach RAM. Addresses outside the window are not claimed: all three outputs stay low and another decoder handles them. All outputs are combinational from the address, the cycle status and the control register. There is no streaming data path, so every pin is a plain level signal.

Top module: `boot_overlay`

## Requirements
- R1: After reset is released the control register holds 3'b001. That is, ROM on (bit 0 = 1), write protect off (bit 1 = 0) and fetch split off (bit 2 = 0). A data read in the window then selects ROM, and a write in the window selects RAM with its write enable set.
- R2: While rst_n is low, a read in the window selects ROM, whatever was last written to the control register.
- R3: The window is addresses with all bits above bit 15 zero and bits 15:14 both one. Any other address gives rom_sel = ram_sel = ram_we = 0.
- R4: With bit 0 = 1 and bit 2 = 0, every valid read in the window selects ROM only.
- R5: With bit 1 = 0, every valid write in the window asserts ram_sel and ram_we and never rom_sel, whatever the values of bits 0 and 2.
- R6: With bit 0 = 0, every valid read in the window selects RAM only. Bit 2 has no effect in this case.
- R7: With bit 1 = 1, a valid write in the window drives all three outputs low. Reads are unaffected.
- R8: With bits 0 and 2 both 1, a read in the window selects ROM when it is a vector pull (vec_pull_n = 0) or a program fetch (prog_vld = 1). Any other valid read (data_vld = 1 only) selects RAM.
- R9: A cycle with prog_vld = 0, data_vld = 0 and vec_pull_n = 1 is idle and drives all outputs low.
- R10: When cfg_we is high at a rising clock edge, cfg_wdata[2:0] replaces the control register. The new value governs routing only after that edge.
- R11: rom_sel and ram_sel are never high together. ram_we is high only when ram_sel is high and bus_rd is low. rom_sel is high only when bus_rd is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low asynchronous reset; forces ROM into the window while low |
| bus_addr | input | ADDR_W (24) | Byte address of the current bus cycle |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| prog_vld | input | 1 | Cycle is a program fetch |
| data_vld | input | 1 | Cycle carries a valid data address |
| vec_pull_n | input | 1 | Active-low vector-pull status |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control value: bit 0 ROM on, bit 1 RAM write protect, bit 2 fetch split |
| rom_sel | output | 1 | Boot ROM chip enable |
| ram_sel | output | 1 | RAM chip enable for the window |
| ram_we | output | 1 | RAM write enable for the window |

## Verification
The bench goes after the window edges 0x00BFFF, 0x00C000 and 0x00FFFF, including the same offsets in banks 1 and 0x80. A decoder that ignored the bank bits would claim the upper banks, and one with an off-by-one boundary would claim 0x00BFFF. Every control value is tried against every combination of read/write and cycle status. This exposes a split mode that sends data reads to ROM or lets vector pulls reach RAM, a protect bit that still pulses the RAM enable on a dropped write, and writes that go to ROM while the overlay is on. Reset is asserted after software has turned the ROM off, so a design that only reloads the register on an edge, and does not force ROM during reset, fails. The register write is probed just before and just after its edge, which catches an update that takes effect too early.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  localparam int CTRL_W = 3;

  // Bit order is visible to software: bit 0 ROM on, bit 1 RAM protect, bit 2 fetch split.
  typedef struct packed {
    logic fetch_split;
    logic ram_ro;
    logic rom_on;
  } ovl_ctrl_t;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_DATA   = 2'd1,
    CYC_FETCH  = 2'd2,
    CYC_VECTOR = 2'd3
  } cyc_kind_t;

  localparam ovl_ctrl_t CTRL_RESET = '{fetch_split: 1'b0, ram_ro: 1'b0, rom_on: 1'b1};
endpackage

// File: rtl/boot_ovl_ctrl_reg.sv
module boot_ovl_ctrl_reg
  import boot_ovl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ovl_ctrl_t         ctrl_o
);
  ovl_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RESET;
    else if (wr_en) ctrl_q <= ovl_ctrl_t'(wr_data);
  end

  // ROM stays forced on for as long as reset is held, not only at its edge.
  always_comb begin
    ctrl_o = ctrl_q;
    if (!rst_n) ctrl_o.rom_on = 1'b1;
  end
endmodule

// File: rtl/boot_ovl_cycle_class.sv
module boot_ovl_cycle_class
  import boot_ovl_pkg::*;
(
  input  logic      prog_vld,
  input  logic      data_vld,
  input  logic      vec_pull_n,
  output cyc_kind_t kind_o
);
  always_comb begin
    if (!vec_pull_n)   kind_o = CYC_VECTOR;
    else if (prog_vld) kind_o = CYC_FETCH;
    else if (data_vld) kind_o = CYC_DATA;
    else               kind_o = CYC_IDLE;
  end
endmodule

// File: rtl/boot_ovl_window.sv
module boot_ovl_window #(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_o
);
  localparam int BANK_LSB = 16;
  localparam int TOP_W    = BANK_LSB - WIN_LOG2;

  logic top_ones;
  assign top_ones = (addr[BANK_LSB-1:WIN_LOG2] == {TOP_W{1'b1}});

  generate
    if (ADDR_W > BANK_LSB) begin : g_banked
      assign hit_o = top_ones && (addr[ADDR_W-1:BANK_LSB] == '0);
    end else begin : g_flat
      assign hit_o = top_ones;
    end
  endgenerate
endmodule

// File: rtl/boot_ovl_route.sv
module boot_ovl_route
  import boot_ovl_pkg::*;
(
  input  logic      hit,
  input  logic      rd,
  input  cyc_kind_t kind,
  input  ovl_ctrl_t ctrl,
  output logic      rom_sel_o,
  output logic      ram_sel_o,
  output logic      ram_we_o
);
  logic active;
  logic to_rom;

  always_comb begin
    active = hit && (kind != CYC_IDLE);
    to_rom = ctrl.rom_on &&
             (!ctrl.fetch_split || kind == CYC_FETCH || kind == CYC_VECTOR);
    rom_sel_o = active && rd && to_rom;
    ram_sel_o = active && (rd ? !to_rom : !ctrl.ram_ro);
    ram_we_o  = active && !rd && !ctrl.ram_ro;
  end
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay
  import boot_ovl_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              prog_vld,
  input  logic              data_vld,
  input  logic              vec_pull_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              ram_we
);
  ovl_ctrl_t ctrl;
  cyc_kind_t kind;
  logic      hit;

  boot_ovl_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata), .ctrl_o(ctrl)
  );

  boot_ovl_cycle_class u_cls (
    .prog_vld(prog_vld), .data_vld(data_vld), .vec_pull_n(vec_pull_n), .kind_o(kind)
  );

  boot_ovl_window #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_win (
    .addr(bus_addr), .hit_o(hit)
  );

  boot_ovl_route u_route (
    .hit(hit), .rd(bus_rd), .kind(kind), .ctrl(ctrl),
    .rom_sel_o(rom_sel), .ram_sel_o(ram_sel), .ram_we_o(ram_we)
  );
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              prog_vld,
  input logic              data_vld,
  input logic              vec_pull_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_wdata,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic              ram_we
);
  logic [2:0] shadow_q;
  logic       in_win;
  logic       idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= 3'b001;
    else if (cfg_we) shadow_q <= cfg_wdata;
  end

  assign in_win = (bus_addr >> 14) == 3;
  assign idle   = !prog_vld && !data_vld && vec_pull_n;

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && ram_sel));
  a_r11_we_needs_ram: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_sel && !bus_rd));
  a_r11_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> bus_rd);
  a_r3_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> !(rom_sel || ram_sel || ram_we));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !(rom_sel || ram_sel || ram_we));
  a_r7_protect_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q[1] && !bus_rd) |-> !(ram_we || ram_sel));
  a_r6_rom_off_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_q[0] |-> !rom_sel);
endmodule

bind boot_overlay boot_overlay_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .prog_vld(prog_vld), .data_vld(data_vld), .vec_pull_n(vec_pull_n),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we)
);

// File: tb/boot_overlay_tb_top.sv
module boot_overlay_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b1;
  logic        prog_vld = 1'b0;
  logic        data_vld = 1'b0;
  logic        vec_pull_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic        rom_sel, ram_sel, ram_we;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  boot_overlay dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .prog_vld(prog_vld), .data_vld(data_vld), .vec_pull_n(vec_pull_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we)
  );

  // Result vector order: {rom_sel, ram_sel, ram_we}
  task automatic chk(input string tag, input logic [2:0] exp);
    checks++;
    if ({rom_sel, ram_sel, ram_we} !== exp) begin
      failures++;
      $display("FAIL %s addr=%h rd=%0b p=%0b d=%0b vn=%0b actual=%b expected=%b",
               tag, bus_addr, bus_rd, prog_vld, data_vld, vec_pull_n,
               {rom_sel, ram_sel, ram_we}, exp);
    end
  endtask

  task automatic drive(input logic [23:0] a, input logic rd, input logic p,
                       input logic d, input logic vn);
    bus_addr = a; bus_rd = rd; prog_vld = p; data_vld = d; vec_pull_n = vn;
  endtask

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [2:0] model(input logic [23:0] a, input logic [2:0] c,
                                       input logic rd, input logic p,
                                       input logic d, input logic vn);
    logic win, valid, rom_path;
    win      = ((a / 65536) == 0) && ((a % 65536) >= 49152);
    valid    = p || d || !vn;
    rom_path = c[0] && (!c[2] || p || !vn);
    if (!win || !valid) return 3'b000;
    if (!rd)            return c[1] ? 3'b000 : 3'b011;
    return rom_path ? 3'b100 : 3'b010;
  endfunction

  function automatic string tag_of(input logic [23:0] a, input logic [2:0] c,
                                   input logic rd, input logic p,
                                   input logic d, input logic vn);
    if (!(((a / 65536) == 0) && ((a % 65536) >= 49152))) return "R3";
    if (!(p || d || !vn)) return "R9";
    if (!rd) return c[1] ? "R7" : "R5";
    if (!c[0]) return "R6";
    return c[2] ? "R8" : "R4";
  endfunction

  initial begin : watchdog
    #(200000 * 20);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [23:0] a;
    logic [23:0] bank;
    // R2: ROM forced while reset is held
    drive(24'h00FFFC, 1'b1, 1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    #1 chk("R2", 3'b100);

    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1", 3'b100);
    drive(24'h00C010, 1'b0, 1'b0, 1'b1, 1'b1);
    #1 chk("R1", 3'b011);

    // R10: write ROM off, takes effect only after the edge
    drive(24'h00E000, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 3'b000;
    #1 chk("R10", 3'b100);
    @(posedge clk);
    #1 chk("R10", 3'b010);
    @(negedge clk);
    cfg_we = 1'b0;

    // R2: reset reasserted after software cleared ROM-on
    rst_n = 1'b0;
    #1 chk("R2", 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1", 3'b100);

    // Sweep: all control values x boundary addresses x all cycle kinds
    for (int c = 0; c < 8; c++) begin
      write_cfg(3'(c));
      for (int b = 0; b < 3; b++) begin
        bank = (b == 0) ? 24'h000000 : (b == 1) ? 24'h010000 : 24'h800000;
        for (int o = 0; o < 16; o++) begin
          a = bank + 24'((o / 2) * 24'h2000) + ((o % 2) != 0 ? 24'h1FFF : 24'h0);
          for (int m = 0; m < 16; m++) begin
            drive(a, m[3], m[2], m[1], m[0]);
            #1;
            chk(tag_of(a, 3'(c), m[3], m[2], m[1], m[0]),
                model(a, 3'(c), m[3], m[2], m[1], m[0]));
            checks++;
            if (rom_sel && ram_sel) begin
              failures++;
              $display("FAIL R11 both selects actual=%b expected=0", {rom_sel, ram_sel});
            end
            #1;
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule